// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block connects a synchronous request/acknowledge port to an external asynchronous static RAM of 128K words by 16 bits. A client holds `req_i` high and supplies a direction, a 17-bit word address, write data and a two-bit byte mask. The controller then runs one access on the memory pins: one setup cycle, a strobe of counted wait states, and one hold cycle. It finishes with a single-cycle `done_o` pulse. Read data is valid on `rdata_o` from the pulse onward.

The memory needs no clock and no refresh, so the controller never issues background cycles. Between accesses the part is parked in standby: the low-active select is high, the high-active select is low and both byte strobes are high. The strobe length is `ceil(ACCESS_NS / CLK_NS)` cycles. This covers any speed grade of the part.

The 16-bit data pins are bidirectional and are driven per byte lane. A lane drives only while the write strobe is low and its mask bit is set. The controller releases the pins before any later read enables the memory's outputs.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and between accesses: `mem_ce1_no`=1, `mem_ce2_o`=0, `mem_ub_no`=1, `mem_lb_no`=1, `mem_we_no`=1, `mem_oe_no`=1 and `done_o`=0.
- R2: For a read (`we_i`=0), `mem_oe_no` is low with `mem_we_no` high for the strobe. `rdata_o` then holds the memory word on the lanes whose `be_i` bit is set and zero on the other lanes. `be_i[1]` selects bits 15:8 and `be_i[0]` selects bits 7:0.
- R3: A write (`we_i`=1) with `be_i`=2'b11 stores all 16 bits of `wdata_i` at `addr_i`.
- R4: A write with one `be_i` bit set changes only that byte lane. The other byte of the word keeps its value.
- R5: A request with `be_i`=2'b00 keeps both byte strobes high. The memory word is unchanged, and `done_o` still pulses.
- R6: The address and byte strobes are valid, with the chip selected, for one cycle before the strobe falls. They stay unchanged for one cycle after it rises.
- R7: `mem_oe_no` never falls in the cycle right after a cycle with `mem_we_no` low. It is never low together with `mem_we_no`.
- R8: Each request gives exactly one single-cycle `done_o` pulse. The pulse comes WAIT+2 cycles after the cycle in which the request was first presented to an idle controller.
- R9: The strobe (`mem_we_no` or `mem_oe_no` low) lasts exactly WAIT = ceil(ACCESS_NS/CLK_NS) cycles. This is 11 with the defaults of 55 ns and 5 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until `done_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte mask, bit 1 upper lane, bit 0 lower lane |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, masked lanes zero |
| mem_addr_o | output | 17 | Memory address |
| mem_ce1_no | output | 1 | Chip select, active low |
| mem_ce2_o | output | 1 | Chip select, active high |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_ub_no | output | 1 | Upper byte strobe, active low |
| mem_lb_no | output | 1 | Lower byte strobe, active low |
| mem_dq_io | inout | 16 | Memory data pins |

## Verification
The write-data release and the output enable of a following read can meet on the same bus cycles. The bench provokes this by presenting a read in the very cycle after a write's `done_o`. A monitor flags any cycle where `mem_oe_no` is low while `mem_we_no` is low or was low one cycle before. The monitor also reads the word back to confirm that no corrupted value was stored. Every access is also traced cycle by cycle to measure the setup, strobe and hold windows against R6 and R9.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       zero_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       load_o,
  output logic       dec_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i)  state_d = ST_SETUP;
      ST_SETUP:              state_d = ST_STROBE;
      ST_STROBE: if (zero_i) state_d = ST_HOLD;
      ST_HOLD:               state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign accept_o = (state_q == ST_IDLE) && req_i;
  assign load_o   = (state_q == ST_SETUP);
  assign dec_o    = (state_q == ST_STROBE);
endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drive_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic              en_i,
  inout  wire  [LANE_W-1:0] pad_io,
  output logic [LANE_W-1:0] rdata_o
);
  assign pad_io = drive_i ? wdata_i : {LANE_W{1'bz}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= en_i ? pad_io : '0;
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ACCESS_NS = 55,
  parameter int unsigned CLK_NS    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce1_no,
  output logic              mem_ce2_o,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_ub_no,
  output logic              mem_lb_no,
  inout  wire  [DATA_W-1:0] mem_dq_io
);
  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned WAIT_RAW = (ACCESS_NS + CLK_NS - 1) / CLK_NS;
  localparam int unsigned WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int unsigned CNT_W    = $clog2(WAIT_CYC + 1);

  seq_state_e         state;
  logic               accept, load, dec, zero;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   be_q;
  logic               wr_q;
  logic               sel, strobe, capture;
  logic [LANES-1:0]   drive;

  sram_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .zero_i   (zero),
    .state_o  (state),
    .accept_o (accept),
    .load_o   (load),
    .dec_o    (dec)
  );

  sram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (CNT_W'(WAIT_CYC - 1)),
    .dec_i      (dec),
    .zero_o     (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
      wr_q    <= we_i;
    end
  end

  assign sel     = (state != ST_IDLE);
  assign strobe  = (state == ST_STROBE);
  assign capture = strobe && !wr_q && zero;

  assign mem_addr_o = addr_q;
  assign mem_ce1_no = !sel;
  assign mem_ce2_o  = sel;
  assign mem_ub_no  = !(sel && be_q[LANES-1]);
  assign mem_lb_no  = !(sel && be_q[0]);
  assign mem_we_no  = !(strobe && wr_q);
  assign mem_oe_no  = !(strobe && !wr_q);
  assign done_o     = (state == ST_HOLD);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign drive[g] = strobe && wr_q && be_q[g];
    sram_lane_io #(.LANE_W(8)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .drive_i   (drive[g]),
      .wdata_i   (wdata_q[g*8 +: 8]),
      .capture_i (capture),
      .en_i      (be_q[g]),
      .pad_io    (mem_dq_io[g*8 +: 8]),
      .rdata_o   (rdata_o[g*8 +: 8])
    );
  end

  // R6: chip selected and address settled a cycle before the write strobe
  p_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> !$past(mem_ce1_no) && $stable(mem_addr_o));

  // R6: address and lanes held across strobe release
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> !mem_ce1_no && $stable(mem_addr_o)
                         && $stable(mem_ub_no) && $stable(mem_lb_no));

  // R7: no output enable right after a write strobe
  p_turnaround_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_no) |-> $past(mem_we_no));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2: read strobe ends exactly as the completion pulse starts
  p_read_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> done_o);
endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
  localparam int WAIT = (55 + 5 - 1) / 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        done;
  logic [15:0] rdata;
  logic [16:0] m_addr;
  logic        ce1_n, ce2, oe_n, we_n, ub_n, lb_n;
  wire  [15:0] dq;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_ce1_no(ce1_n), .mem_ce2_o(ce2),
    .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_ub_no(ub_n), .mem_lb_no(lb_n),
    .mem_dq_io(dq)
  );

  // memory model, low 9 address bits decoded
  logic [15:0] mdl [0:511];
  logic [15:0] mdl_rd;
  logic        mdl_sel, mdl_rd_en;
  assign mdl_sel   = !ce1_n && ce2;
  assign mdl_rd_en = mdl_sel && we_n && !oe_n;
  assign mdl_rd    = mdl[m_addr[8:0]];
  assign dq[7:0]   = (mdl_rd_en && !lb_n) ? mdl_rd[7:0]  : 8'bz;
  assign dq[15:8]  = (mdl_rd_en && !ub_n) ? mdl_rd[15:8] : 8'bz;

  always @(negedge clk) begin
    if (mdl_sel && !we_n) begin
      if (!lb_n) mdl[m_addr[8:0]][7:0]  <= dq[7:0];
      if (!ub_n) mdl[m_addr[8:0]][15:8] <= dq[15:8];
    end
  end

  // R7 contention monitor
  logic prev_we_low = 1'b0;
  int   turn_viol = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!oe_n && (!we_n || prev_we_low)) turn_viol++;
      prev_we_low <= !we_n;
    end
  end

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(ce1_n && !ce2 && ub_n && lb_n && we_n && oe_n && !done, tag,
        {26'd0, ce1_n, ce2, ub_n, lb_n, we_n, oe_n}, 32'h2F);
  endtask

  // one access with cycle-level tracing of R6, R8, R9
  task automatic access(input bit w, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] b);
    int n = 0, strobes = 0, dones = 0, done_at = 0;
    bit setup_ok = 0, hold_ok = 0, addr_ok = 1;
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    while (done_at == 0 && n < 100) begin
      @(negedge clk);
      n++;
      if (!ce1_n && m_addr != a) addr_ok = 0;
      if (!we_n || !oe_n) strobes++;
      if (n == 1)
        setup_ok = !ce1_n && ce2 && we_n && oe_n && (ub_n == !b[1]) && (lb_n == !b[0]);
      if (done) begin
        dones++;
        done_at = n;
        hold_ok = !ce1_n && ce2 && we_n && oe_n && (ub_n == !b[1]) && (lb_n == !b[0]);
        req = 1'b0;
      end
    end
    chk(done_at == WAIT + 2, "R8 latency", done_at, WAIT + 2);
    chk(strobes == WAIT, "R9 strobe width", strobes, WAIT);
    chk(setup_ok && hold_ok && addr_ok, "R6 setup/hold", {setup_ok, hold_ok, addr_ok}, 3'b111);
    @(negedge clk);
    chk(!done, "R8 single pulse", done, 0);
    chk_idle("R1 idle after access");
  endtask

  task automatic t_reset;
    chk_idle("R1 reset state");
  endtask

  task automatic t_full_write_read;
    access(1, 17'h00001, 16'hA5C3, 2'b11);
    access(0, 17'h00001, 16'h0, 2'b11);
    chk(rdata == 16'hA5C3, "R3 full write readback", rdata, 16'hA5C3);
  endtask

  task automatic t_byte_writes;
    access(1, 17'h00001, 16'h7E00, 2'b10);
    access(0, 17'h00001, 16'h0, 2'b11);
    chk(rdata == 16'h7EC3, "R4 upper byte write", rdata, 16'h7EC3);
    access(1, 17'h00001, 16'h0019, 2'b01);
    access(0, 17'h00001, 16'h0, 2'b11);
    chk(rdata == 16'h7E19, "R4 lower byte write", rdata, 16'h7E19);
  endtask

  task automatic t_lane_read;
    access(0, 17'h00001, 16'h0, 2'b01);
    chk(rdata == 16'h0019, "R2 lower lane read", rdata, 16'h0019);
    access(0, 17'h00001, 16'h0, 2'b10);
    chk(rdata == 16'h7E00, "R2 upper lane read", rdata, 16'h7E00);
  endtask

  task automatic t_no_lanes;
    access(1, 17'h00001, 16'hFFFF, 2'b00);
    access(0, 17'h00001, 16'h0, 2'b11);
    chk(rdata == 16'h7E19, "R5 masked write ignored", rdata, 16'h7E19);
  endtask

  task automatic t_top_addr_turnaround;
    access(1, 17'h1FFFF, 16'h1234, 2'b11);
    access(0, 17'h1FFFF, 16'h0, 2'b11);
    chk(rdata == 16'h1234, "R7 back-to-back readback", rdata, 16'h1234);
    access(1, 17'h00001, 16'hBEEF, 2'b11);
    access(0, 17'h1FFFF, 16'h0, 2'b11);
    chk(rdata == 16'h1234, "R3 distinct word kept", rdata, 16'h1234);
    chk(turn_viol == 0, "R7 no bus contention", turn_viol, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mdl[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write_read();
    t_byte_writes();
    t_lane_read();
    t_no_lanes();
    t_top_addr_turnaround();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule